// File: doc/BRIEF.md
# ADPCM Block Command Sequencer

This block walks a byte stream of playback commands and packed sample data and turns it into a timed sequence of 4-bit nibbles for an ADPCM decoder. Each block in the stream opens with a header byte whose two top bits select its kind: a timed gap of silence, a block with a fixed length of 256 nibbles, a block whose nibble count comes in the byte after the header, or a loop marker that repeats the block after it. The nibble and silence headers also reload the sample period.

Bytes come in over a valid/ready handshake. The block presents the index of the byte it wants next on `byte_idx`, so a plain memory reader can serve it. When a repeat loop is active, the block pulses `rewind` and reloads `byte_idx` from `rpt_point`. The byte source then moves its read pointer back to that index. Toward the decoder, the block sends one nibble strobe per sample slot and a clear strobe at each silence gap. It raises a one-cycle `done` when the stream ends.

Top module: `adpcm_cmd_seq`

## Requirements
- R1: Bits [7:6] of a header select its kind. 2'b00 is silence, 2'b01 is a 256-nibble block, 2'b10 is a block whose count byte follows, and 2'b11 is a repeat marker.
- R2: For kinds 2'b01 and 2'b10, a nibble slot lasts (header[5:0]+1)*NIB_MULT clocks. While the source keeps `in_valid` high, consecutive `nib_valid` strobes in a block are exactly one slot apart.
- R3: For kind 2'b10, the byte after the header, plus one, gives the number of nibbles played.
- R4: A silence header pulses `dec_clear` and waits SIL_UNIT*(header[5:0]+1) clocks. The next header is accepted one cycle after that wait ends, so a second silence header strobes `dec_clear` SIL_UNIT*(d+1)+1 cycles after the first.
- R5: A repeat header loads a count of header[2:0]+1 and sets `rpt_point` to the index of the byte after it. Each later header fetch made while the count is nonzero pulses `rewind`, reloads `byte_idx` with `rpt_point` and decrements the count. The block after the marker therefore plays header[2:0]+1 times in all.
- R6: Once a nonzero header has been seen since start, a header of 8'h00 ends playback: `done` pulses and `busy` falls. Before any nonzero header, 8'h00 acts as a silence of length one unit.
- R7: Each data byte gives its upper nibble first and then its lower one. When the count runs out after an upper nibble, the lower nibble is dropped and the next byte is read as a header.
- R8: `start` is acted on only while idle, and a pulse while busy has no effect on playback. `busy` is high whenever the block is not idle. `in_ready` is low while idle.
- R9: A synchronous `rst` returns the block to idle and clears the repeat count, the nibble count and the seen-nonzero-header flag.
- R10: `byte_idx` is zero after start and advances by one on every accepted byte. While `in_valid` is low the block waits, and the nibble values it plays do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin playback from byte index 0 |
| busy | output | 1 | High while not idle |
| in_data | input | 8 | Byte at index `byte_idx` |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Block accepts `in_data` this cycle |
| byte_idx | output | ADDR_W | Index of the byte wanted next |
| rpt_point | output | ADDR_W | Byte index a rewind returns to |
| rewind | output | 1 | One-cycle strobe: source restarts at `rpt_point` |
| nib_out | output | 4 | Nibble for the decoder |
| nib_valid | output | 1 | One-cycle strobe: `nib_out` is new |
| dec_clear | output | 1 | One-cycle strobe: clear decoder sample and step state |
| done | output | 1 | One-cycle strobe: end-of-sample header reached |

## Verification
The bench builds the block with SIL_UNIT=4, NIB_MULT=2 and ADDR_W=9. With these values a silence unit lasts only a few cycles, and the shortest nibble slot is two cycles, so exact cycle spacing is measurable. The bench sweeps nibble counts 1 to 6 against three period codes, covers every repeat count 0 to 7, and plays a full 256-nibble block, all well within budget. The memory-style source serves each byte at the index the block presents, so a wrong index, rewind or count shows up as wrong nibble values.

// File: rtl/adpcm_cmd_seq.sv
module adpcm_cmd_seq #(
  parameter int ADDR_W   = 17,
  parameter int SIL_UNIT = 1024,
  parameter int NIB_MULT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [ADDR_W-1:0] byte_idx,
  output logic [ADDR_W-1:0] rpt_point,
  output logic              rewind,
  output logic [3:0]        nib_out,
  output logic              nib_valid,
  output logic              dec_clear,
  output logic              done
);

  localparam int TMR_MAX = ((SIL_UNIT > NIB_MULT) ? SIL_UNIT : NIB_MULT) * 64;
  localparam int TMR_W   = $clog2(TMR_MAX);

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_HGO, S_CNT, S_DATA, S_HI, S_LO, S_SIL
  } st_t;

  st_t              st;
  logic [TMR_W-1:0] tmr;
  logic [8:0]       nleft;
  logic [3:0]       rcnt;
  logic             seen;
  logic [5:0]       per;
  logic [3:0]       lo_nib;

  logic [TMR_W-1:0] slot_m1, sil_len;
  logic             lo_end, hdr_st, take, hdr_take, data_take;

  assign slot_m1  = TMR_W'((int'(per) + 1) * NIB_MULT - 1);
  assign sil_len  = TMR_W'((int'(in_data[5:0]) + 1) * SIL_UNIT - 1);
  assign lo_end   = (st == S_LO) && (tmr == '0) && (nleft != '0);
  assign hdr_st   = (st == S_HGO) || ((st == S_HDR) && (rcnt == '0));
  assign in_ready = hdr_st || (st == S_CNT) || (st == S_DATA) || lo_end;
  assign take     = in_valid && in_ready;
  assign hdr_take = take && hdr_st;
  assign data_take = take && ((st == S_DATA) || lo_end);
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      tmr       <= '0;
      nleft     <= '0;
      rcnt      <= '0;
      seen      <= 1'b0;
      per       <= '0;
      lo_nib    <= '0;
      byte_idx  <= '0;
      rpt_point <= '0;
      rewind    <= 1'b0;
      nib_out   <= '0;
      nib_valid <= 1'b0;
      dec_clear <= 1'b0;
      done      <= 1'b0;
    end else begin
      rewind    <= 1'b0;
      nib_valid <= 1'b0;
      dec_clear <= 1'b0;
      done      <= 1'b0;
      if (take) byte_idx <= byte_idx + ADDR_W'(1);

      case (st)
        S_IDLE: if (start) begin
          st       <= S_HDR;
          rcnt     <= '0;
          seen     <= 1'b0;
          byte_idx <= '0;
        end
        S_HDR: if (rcnt != '0) begin
          rewind   <= 1'b1;
          byte_idx <= rpt_point;
          rcnt     <= rcnt - 4'd1;
          st       <= S_HGO;
        end
        S_CNT: if (take) begin
          nleft <= 9'(in_data) + 9'd1;
          st    <= S_DATA;
        end
        S_HI: begin
          if (tmr != '0) tmr <= tmr - TMR_W'(1);
          else if (nleft == '0) st <= S_HDR;
          else begin
            nib_out   <= lo_nib;
            nib_valid <= 1'b1;
            nleft     <= nleft - 9'd1;
            tmr       <= slot_m1;
            st        <= S_LO;
          end
        end
        S_LO: begin
          if (tmr != '0) tmr <= tmr - TMR_W'(1);
          else if (nleft == '0) st <= S_HDR;
          else if (!in_valid) st <= S_DATA;
        end
        S_SIL: begin
          if (tmr != '0) tmr <= tmr - TMR_W'(1);
          else st <= S_HDR;
        end
        default: ;
      endcase

      if (data_take) begin
        nib_out   <= in_data[7:4];
        lo_nib    <= in_data[3:0];
        nib_valid <= 1'b1;
        nleft     <= nleft - 9'd1;
        tmr       <= slot_m1;
        st        <= S_HI;
      end

      if (hdr_take) begin
        if (in_data != 8'h00) seen <= 1'b1;
        case (in_data[7:6])
          2'b00: begin
            if (in_data == 8'h00 && seen) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              tmr       <= sil_len;
              dec_clear <= 1'b1;
              st        <= S_SIL;
            end
          end
          2'b01: begin
            per   <= in_data[5:0];
            nleft <= 9'd256;
            st    <= S_DATA;
          end
          2'b10: begin
            per <= in_data[5:0];
            st  <= S_CNT;
          end
          default: begin
            rcnt      <= 4'(in_data[2:0]) + 4'd1;
            rpt_point <= byte_idx + ADDR_W'(1);
            st        <= S_HDR;
          end
        endcase
      end
    end
  end

  AST_REWIND_IDX: assert property (@(posedge clk) disable iff (rst)
    rewind |-> (byte_idx == rpt_point)); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R6

  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R8

  AST_READY_BUSY: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> busy); // R8

  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (rst)
    dec_clear |=> !nib_valid); // R4

  AST_NIB_BUSY: assert property (@(posedge clk) disable iff (rst)
    nib_valid |-> busy); // R7

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({nib_valid, dec_clear, rewind}) <= 1); // R1

endmodule

// File: tb/adpcm_cmd_seq_tb_top.sv
module adpcm_cmd_seq_tb_top;
  localparam int AW = 9;
  localparam int SU = 4;
  localparam int NM = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic in_valid = 1'b1;
  logic busy, in_ready, rewind, nib_valid, dec_clear, done;
  logic [7:0] in_data;
  logic [AW-1:0] byte_idx, rpt_point;
  logic [3:0] nib_out;
  logic [7:0] mem [0:511];

  always #5 clk = ~clk;
  assign in_data = mem[byte_idx];

  adpcm_cmd_seq #(.ADDR_W(AW), .SIL_UNIT(SU), .NIB_MULT(NM)) dut_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .byte_idx(byte_idx), .rpt_point(rpt_point), .rewind(rewind),
    .nib_out(nib_out), .nib_valid(nib_valid), .dec_clear(dec_clear), .done(done));

  int checks = 0, errors = 0, cyc = 0;
  bit gap_mode = 1'b0;
  int nv_cnt, clr_cnt, rw_cnt, done_cnt;
  logic [3:0] nv_val [0:511];
  int nv_t [0:511];
  int clr_t [0:15];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) in_valid = gap_mode ? ((cyc % 3) != 0) : 1'b1;

  always @(negedge clk) begin
    if (nib_valid && nv_cnt < 512) begin nv_val[nv_cnt] = nib_out; nv_t[nv_cnt] = cyc; nv_cnt++; end
    if (dec_clear && clr_cnt < 16) begin clr_t[clr_cnt] = cyc; clr_cnt++; end
    if (rewind) rw_cnt++;
    if (done) done_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_mem();
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
  endtask

  function automatic logic [7:0] seq_byte(input int i);
    return {4'((2*i+1) & 15), 4'((2*i+2) & 15)};
  endfunction

  task automatic go(input bit poke);
    int t;
    nv_cnt = 0; clr_cnt = 0; rw_cnt = 0; done_cnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      t = 0;
      while (nv_cnt < 1 && t < 5000) begin @(negedge clk); t++; end
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    if (busy) chk("R8 run did not end", 1, 0);
    repeat (3) @(negedge clk);
  endtask

  function automatic int seq_err(input int n);
    int e = 0;
    for (int k = 0; k < n; k++) if (nv_val[k] != 4'((k+1) & 15)) e++;
    return e;
  endfunction

  function automatic int gap_err(input int n, input int slot);
    int e = 0;
    for (int k = 0; k + 1 < n; k++) if (nv_t[k+1] - nv_t[k] != slot) e++;
    return e;
  endfunction

  initial begin
    clr_mem();
    repeat (3) @(negedge clk);
    chk("R9 busy in reset", int'(busy), 0);
    chk("R8 in_ready in reset", int'(in_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 busy idle", int'(busy), 0);
    chk("R8 in_ready idle", int'(in_ready), 0);
    chk("R7 nib_valid idle", int'(nib_valid), 0);

    // counted blocks: R2 R3 R7 R10 R6, start poke R8
    foreach (mem[i]) ;
    for (int fi = 0; fi < 3; fi++) begin
      for (int n = 1; n <= 6; n++) begin
        int f = (fi == 0) ? 0 : ((fi == 1) ? 1 : 5);
        clr_mem();
        mem[0] = 8'h80 | 8'(f);
        mem[1] = 8'(n - 1);
        for (int i = 0; i < (n + 1) / 2; i++) mem[2+i] = seq_byte(i);
        go(f == 5 && n == 6);
        chk("R3 nibble count", nv_cnt, n);
        chk("R7 R10 nibble values", seq_err(n), 0);
        chk("R2 slot spacing", gap_err(n, (f + 1) * NM), 0);
        chk("R6 done once", done_cnt, 1);
        chk("R8 busy after end", int'(busy), 0);
      end
    end

    // 256-nibble block: R1
    clr_mem();
    mem[0] = 8'h40;
    for (int i = 0; i < 128; i++) mem[1+i] = seq_byte(i);
    go(1'b0);
    chk("R1 256 nibbles", nv_cnt, 256);
    chk("R1 256 values", seq_err(256), 0);
    chk("R2 256 spacing", gap_err(256, NM), 0);

    // repeat loop: R5
    for (int r = 0; r < 8; r++) begin
      int e = 0;
      clr_mem();
      mem[0] = 8'hC0 | 8'(r);
      mem[1] = 8'h80; mem[2] = 8'h01; mem[3] = 8'hAB;
      go(1'b0);
      chk("R5 nibbles", nv_cnt, 2 * (r + 1));
      chk("R5 rewinds", rw_cnt, r + 1);
      chk("R5 rpt_point", int'(rpt_point), 1);
      for (int k = 0; k < nv_cnt; k++) if (nv_val[k] != ((k % 2) ? 4'hB : 4'hA)) e++;
      chk("R5 values", e, 0);
    end

    // silence, early zero: R4 R6 R7
    clr_mem();
    mem[0] = 8'h00; mem[1] = 8'h03; mem[2] = 8'h80; mem[3] = 8'h00; mem[4] = 8'h5C;
    go(1'b0);
    chk("R6 early zero is silence", clr_cnt, 2);
    chk("R4 silence gap 1", clr_t[1] - clr_t[0], SU * 1 + 1);
    chk("R4 silence gap 4", nv_t[0] - clr_t[1], SU * 4 + 3);
    chk("R7 odd count drops low", nv_cnt, 1);
    chk("R7 upper first", int'(nv_val[0]), 5);
    chk("R6 done", done_cnt, 1);

    // stalls: R10
    gap_mode = 1'b1;
    clr_mem();
    mem[0] = 8'h80; mem[1] = 8'h04;
    for (int i = 0; i < 3; i++) mem[2+i] = seq_byte(i);
    go(1'b0);
    gap_mode = 1'b0;
    chk("R10 stall count", nv_cnt, 5);
    chk("R10 stall values", seq_err(5), 0);

    // reset mid-loop: R9
    clr_mem();
    mem[0] = 8'hC7; mem[1] = 8'h40;
    for (int i = 0; i < 128; i++) mem[2+i] = seq_byte(i);
    nv_cnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (nv_cnt < 10) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 busy after reset", int'(busy), 0);
    chk("R9 ready after reset", int'(in_ready), 0);
    clr_mem();
    mem[0] = 8'h00; mem[1] = 8'h80; mem[2] = 8'h00; mem[3] = 8'h70;
    go(1'b0);
    chk("R9 seen cleared", clr_cnt, 1);
    chk("R9 nibble after reset", int'(nv_val[0]), 7);
    chk("R9 no rewind", rw_cnt, 0);
    chk("R9 done", done_cnt, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule